// File: doc/BRIEF.md
# I2C Register-Access Slave with Strap-Selected Address

This block is an I2C slave that lets a bus master read and write a bank of 8-bit registers held outside the block. A host addresses the slave, sends an index byte that loads the internal register pointer, and may follow it with one data byte. That data byte is written to the register the pointer selects. A read transaction returns the register at the current pointer.

The slave's 7-bit bus address is one of two values. The choice comes from a strap input that is sampled once, on the first system clock after the power-on reset is released. The result is held until the next reset.

SCL and SDA are oversampled by the system clock through a synchroniser chain. START and STOP conditions and the SCL edges are detected in the system clock domain. SDA is driven open-drain: the output value is tied low, and the block only switches the output enable.

Top module: `i2c_strap_slave`

## Requirements
- R1: With the strap low, the slave acknowledges the 7-bit address 0x4E, which is address byte 0x9C for a write and 0x9D for a read.
- R2: With the strap high, the slave acknowledges 7-bit address 0x37 (bytes 0x6E and 0x6F) and does not acknowledge 0x4E. The strap is taken once, in the first clock after reset release, and a later change on the strap pin has no effect until the next reset.
- R3: An address byte that does not match is not acknowledged. Every byte after it, up to the next START or STOP, is also not acknowledged and changes neither the pointer nor any register.
- R4: A write made of START, address (R/W=0), index, data and STOP is acknowledged on all three bytes. It produces exactly one register write, with reg_addr_o equal to the index and reg_wdata_o equal to the data byte.
- R5: A write that carries only the address and index bytes, then STOP, loads the pointer and issues no register write. A following read returns the register at that index.
- R6: For every accepted byte, the slave holds SDA low through the high phase of the ninth SCL clock and releases it after the ninth falling edge. sda_oe_o changes only while the synchronised SCL is low.
- R7: A read (R/W=1) returns the register at the pointer, MSB first, one bit per SCL clock. The slave releases SDA during the ninth clock so the master can answer, and the pointer stays constant while the byte is sent.
- R8: If the master acknowledges a read byte, the same register is sent again. If the master does not acknowledge, the slave leaves SDA released until the next START or STOP.
- R9: The register write strobe reg_we_o is high for exactly one system clock per data byte. It is raised after the eighth data bit, together with the slave's acknowledge.
- R10: A repeated START, whether it comes after a full byte or in the middle of one, restarts the frame so that the next byte is treated as an address byte.
- R11: A byte that follows the data byte in the same write is not acknowledged and writes nothing. The register written by the data byte keeps that byte's value.
- R12: After reset, sda_oe_o and reg_we_o are 0 and reg_addr_o is 0. sda_o is 0 at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock used to oversample the bus |
| rst_ni | input | 1 | Active-low asynchronous power-on reset |
| strap_i | input | 1 | Address-select strap: 0 selects 0x4E, 1 selects 0x37 |
| scl_i | input | 1 | I2C clock line as seen at the pad |
| sda_i | input | 1 | I2C data line as seen at the pad |
| sda_oe_o | output | 1 | When 1, the pad pulls SDA low |
| sda_o | output | 1 | SDA output value, always 0 (open-drain) |
| reg_addr_o | output | IDX_W | Register pointer presented to the register file |
| reg_wdata_o | output | 8 | Data byte to be written |
| reg_we_o | output | 1 | Single-cycle register write strobe |
| reg_rdata_i | input | 8 | Read data of the register at reg_addr_o |

## Verification
The hardest cases to reach from the ports are a repeated START that arrives partway through a byte, and a strap change that happens after reset without a new reset.

For the first case, the bench clocks a few bits of a byte and then raises SDA while SCL is low, followed by a new START. It then checks that the next byte is acknowledged as an address and that the pointer comes from the index that follows.

For the second case, the bench flips the strap between transactions. It checks that the old address is still answered and the new one is not, and only a second reset changes the choice.

A rejected address, a third byte in a write, and a master NACK on a read are all checked at the bus: the bench reads back acknowledge bits, idle ones and register contents, and never looks at internal state.

// File: rtl/i2c_slv_pkg.sv
package i2c_slv_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_INDEX,
    ST_DATA,
    ST_ACK,
    ST_TX,
    ST_MACK,
    ST_WAIT
  } slv_state_e;

  typedef enum logic [1:0] {
    AK_WR_ADDR,
    AK_RD_ADDR,
    AK_INDEX,
    AK_DATA
  } ack_kind_e;

  localparam int unsigned BYTE_W = 8;
  localparam logic [6:0] DEV_ADDR_LO = 7'h4E;
  localparam logic [6:0] DEV_ADDR_HI = 7'h37;

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);

  logic [STAGES:0] scl_c, sda_c;
  logic scl_d, sda_d;

  assign scl_c[0] = scl_i;
  assign sda_c[0] = sda_i;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        scl_c[g+1] <= 1'b1;
        sda_c[g+1] <= 1'b1;
      end else begin
        scl_c[g+1] <= scl_c[g];
        sda_c[g+1] <= sda_c[g];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_d <= scl_c[STAGES];
      sda_d <= sda_c[STAGES];
    end
  end

  assign scl_o      = scl_c[STAGES];
  assign sda_o      = sda_c[STAGES];
  assign scl_rise_o = scl_o & ~scl_d;
  assign scl_fall_o = ~scl_o & scl_d;
  // SDA edge while SCL stays high
  assign start_o    = scl_o & scl_d & sda_d & ~sda_o;
  assign stop_o     = scl_o & scl_d & ~sda_d & sda_o;

endmodule

// File: rtl/i2c_strap_latch.sv
module i2c_strap_latch #(
  parameter logic [6:0] ADDR_LO = 7'h4E,
  parameter logic [6:0] ADDR_HI = 7'h37
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       strap_i,
  output logic [6:0] dev_addr_o,
  output logic       latched_o
);

  logic sel_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q     <= 1'b0;
      latched_o <= 1'b0;
    end else if (!latched_o) begin
      sel_q     <= strap_i;
      latched_o <= 1'b1;
    end
  end

  assign dev_addr_o = sel_q ? ADDR_HI : ADDR_LO;

endmodule

// File: rtl/i2c_slave_fsm.sv
module i2c_slave_fsm
  import i2c_slv_pkg::*;
#(
  parameter int unsigned IDX_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [6:0]        dev_addr_i,
  input  logic              sda_s_i,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic [BYTE_W-1:0] reg_rdata_i,
  output logic              sda_oe_o,
  output logic [IDX_W-1:0]  reg_addr_o,
  output logic [BYTE_W-1:0] reg_wdata_o,
  output logic              reg_we_o,
  output slv_state_e        state_o
);

  localparam int unsigned CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_W);

  slv_state_e        state_q;
  ack_kind_e         kind_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [BYTE_W-1:0] sh_q;
  logic              mack_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      kind_q      <= AK_WR_ADDR;
      cnt_q       <= '0;
      sh_q        <= '0;
      mack_q      <= 1'b0;
      sda_oe_o    <= 1'b0;
      reg_addr_o  <= '0;
      reg_wdata_o <= '0;
      reg_we_o    <= 1'b0;
    end else begin
      reg_we_o <= 1'b0;
      if (start_i) begin
        state_q  <= ST_ADDR;
        cnt_q    <= '0;
        sda_oe_o <= 1'b0;
      end else if (stop_i) begin
        state_q  <= ST_IDLE;
        sda_oe_o <= 1'b0;
      end else begin
        case (state_q)
          ST_ADDR, ST_INDEX, ST_DATA: begin
            if (scl_rise_i && cnt_q != FULL) begin
              sh_q  <= {sh_q[BYTE_W-2:0], sda_s_i};
              cnt_q <= cnt_q + 1'b1;
            end else if (scl_fall_i && cnt_q == FULL) begin
              cnt_q <= '0;
              case (state_q)
                ST_ADDR: begin
                  if (sh_q[7:1] == dev_addr_i) begin
                    sda_oe_o <= 1'b1;
                    state_q  <= ST_ACK;
                    kind_q   <= sh_q[0] ? AK_RD_ADDR : AK_WR_ADDR;
                  end else begin
                    state_q  <= ST_WAIT;
                  end
                end
                ST_INDEX: begin
                  reg_addr_o <= sh_q[IDX_W-1:0];
                  sda_oe_o   <= 1'b1;
                  state_q    <= ST_ACK;
                  kind_q     <= AK_INDEX;
                end
                default: begin
                  reg_wdata_o <= sh_q;
                  reg_we_o    <= 1'b1;
                  sda_oe_o    <= 1'b1;
                  state_q     <= ST_ACK;
                  kind_q      <= AK_DATA;
                end
              endcase
            end
          end
          ST_ACK: begin
            if (scl_fall_i) begin
              cnt_q <= '0;
              case (kind_q)
                AK_RD_ADDR: begin
                  sh_q     <= reg_rdata_i;
                  sda_oe_o <= ~reg_rdata_i[BYTE_W-1];
                  state_q  <= ST_TX;
                end
                AK_WR_ADDR: begin
                  sda_oe_o <= 1'b0;
                  state_q  <= ST_INDEX;
                end
                AK_INDEX: begin
                  sda_oe_o <= 1'b0;
                  state_q  <= ST_DATA;
                end
                default: begin
                  sda_oe_o <= 1'b0;
                  state_q  <= ST_WAIT;
                end
              endcase
            end
          end
          ST_TX: begin
            if (scl_rise_i && cnt_q != FULL) begin
              cnt_q <= cnt_q + 1'b1;
            end else if (scl_fall_i) begin
              if (cnt_q == FULL) begin
                sda_oe_o <= 1'b0;
                state_q  <= ST_MACK;
              end else begin
                sh_q     <= {sh_q[BYTE_W-2:0], 1'b0};
                sda_oe_o <= ~sh_q[BYTE_W-2];
              end
            end
          end
          ST_MACK: begin
            if (scl_rise_i) begin
              mack_q <= ~sda_s_i;
            end else if (scl_fall_i) begin
              if (mack_q) begin
                sh_q     <= reg_rdata_i;
                sda_oe_o <= ~reg_rdata_i[BYTE_W-1];
                cnt_q    <= '0;
                state_q  <= ST_TX;
              end else begin
                state_q  <= ST_WAIT;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign state_o = state_q;

endmodule

// File: rtl/i2c_strap_slave.sv
module i2c_strap_slave
  import i2c_slv_pkg::*;
#(
  parameter int unsigned IDX_W       = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             strap_i,
  input  logic             scl_i,
  input  logic             sda_i,
  output logic             sda_oe_o,
  output logic             sda_o,
  output logic [IDX_W-1:0] reg_addr_o,
  output logic [7:0]       reg_wdata_o,
  output logic             reg_we_o,
  input  logic [7:0]       reg_rdata_i
);

  logic       scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic [6:0] dev_addr;
  logic       strapped;
  slv_state_e state;

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .scl_o      (scl_s),
    .sda_o      (sda_s),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .start_o    (start_det),
    .stop_o     (stop_det)
  );

  i2c_strap_latch #(.ADDR_LO(DEV_ADDR_LO), .ADDR_HI(DEV_ADDR_HI)) u_strap (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .strap_i    (strap_i),
    .dev_addr_o (dev_addr),
    .latched_o  (strapped)
  );

  i2c_slave_fsm #(.IDX_W(IDX_W)) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .dev_addr_i  (dev_addr),
    .sda_s_i     (sda_s),
    .scl_rise_i  (scl_rise),
    .scl_fall_i  (scl_fall),
    .start_i     (start_det),
    .stop_i      (stop_det),
    .reg_rdata_i (reg_rdata_i),
    .sda_oe_o    (sda_oe_o),
    .reg_addr_o  (reg_addr_o),
    .reg_wdata_o (reg_wdata_o),
    .reg_we_o    (reg_we_o),
    .state_o     (state)
  );

  assign sda_o = 1'b0;

endmodule

// File: rtl/i2c_strap_slave_chk.sv
module i2c_strap_slave_chk
  import i2c_slv_pkg::*;
#(
  parameter int unsigned IDX_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             scl_s,
  input logic             sda_oe_o,
  input logic             reg_we_o,
  input logic [IDX_W-1:0] reg_addr_o,
  input logic [6:0]       dev_addr,
  input logic             strapped,
  input slv_state_e       state
);

  p_we_single_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_o |=> !reg_we_o);

  p_we_acked_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_o |-> sda_oe_o);

  p_addr_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strapped && $past(strapped)) |-> dev_addr == $past(dev_addr));

  p_addr_legal_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strapped |-> (dev_addr == DEV_ADDR_LO || dev_addr == DEV_ADDR_HI));

  p_oe_scl_low_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sda_oe_o != $past(sda_oe_o)) |-> !$past(scl_s));

  p_ptr_hold_tx_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_TX && $past(state) == ST_TX) |-> reg_addr_o == $past(reg_addr_o));

endmodule

bind i2c_strap_slave i2c_strap_slave_chk #(.IDX_W(IDX_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .scl_s      (scl_s),
  .sda_oe_o   (sda_oe_o),
  .reg_we_o   (reg_we_o),
  .reg_addr_o (reg_addr_o),
  .dev_addr   (dev_addr),
  .strapped   (strapped),
  .state      (state)
);

// File: tb/tb_i2c_strap_slave.sv
module tb_i2c_strap_slave;

  localparam int Q = 10;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       strap_i = 1'b0;
  logic       m_scl = 1'b1;
  logic       m_sda = 1'b1;
  logic       sda_bus;
  logic       sda_oe_o, sda_o, reg_we_o;
  logic [7:0] reg_addr_o, reg_wdata_o, reg_rdata_i;

  logic [7:0] rf  [256];
  logic [7:0] exp_mem [256];
  logic [7:0] exp_idx_q[$];
  logic [7:0] exp_dat_q[$];
  int checks = 0;
  int failures = 0;
  bit done = 0;
  logic we_prev = 1'b0;

  always #2.5 clk = ~clk;

  assign sda_bus = m_sda & ~sda_oe_o;
  assign reg_rdata_i = rf[reg_addr_o];

  i2c_strap_slave dut (
    .clk_i(clk), .rst_ni(rst_ni), .strap_i(strap_i),
    .scl_i(m_scl), .sda_i(sda_bus),
    .sda_oe_o(sda_oe_o), .sda_o(sda_o),
    .reg_addr_o(reg_addr_o), .reg_wdata_o(reg_wdata_o),
    .reg_we_o(reg_we_o), .reg_rdata_i(reg_rdata_i)
  );

  always @(posedge clk) if (reg_we_o) rf[reg_addr_o] <= reg_wdata_o;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  // per-clock reference comparison: strobe contents, width, sda_o level
  always @(negedge clk) begin
    if (rst_ni) begin
      chk(sda_o == 1'b0, "R12", "sda_o level", sda_o, 0);
      if (reg_we_o) begin
        chk(!we_prev, "R9", "strobe width", 2, 1);
        if (exp_idx_q.size() == 0) begin
          chk(0, "R9", "unexpected write strobe at index", reg_addr_o, 0);
        end else begin
          logic [7:0] ei, ed;
          ei = exp_idx_q.pop_front();
          ed = exp_dat_q.pop_front();
          chk(reg_addr_o == ei, "R4", "write index", reg_addr_o, ei);
          chk(reg_wdata_o == ed, "R4", "write data", reg_wdata_o, ed);
        end
      end
      we_prev <= reg_we_o;
    end else begin
      we_prev <= 1'b0;
    end
  end

  task automatic wq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic i2c_start();
    m_sda = 1'b1; m_scl = 1'b1; wq();
    m_sda = 1'b0; wq();
    m_scl = 1'b0; wq();
  endtask

  task automatic i2c_rstart();
    m_sda = 1'b1; wq();
    m_scl = 1'b1; wq();
    m_sda = 1'b0; wq();
    m_scl = 1'b0; wq();
  endtask

  task automatic i2c_stop();
    m_sda = 1'b0; wq();
    m_scl = 1'b1; wq();
    m_sda = 1'b1; wq();
  endtask

  task automatic wr_bit(input logic b);
    m_sda = b; wq();
    m_scl = 1'b1; wq(); wq();
    m_scl = 1'b0; wq();
  endtask

  task automatic rd_bit(output logic b);
    m_sda = 1'b1; wq();
    m_scl = 1'b1; wq();
    b = sda_bus; wq();
    m_scl = 1'b0; wq();
  endtask

  task automatic send_byte(input logic [7:0] v, output bit acked);
    logic b;
    for (int i = 7; i >= 0; i--) wr_bit(v[i]);
    rd_bit(b);
    acked = !b;
  endtask

  task automatic recv_byte(output logic [7:0] v, input bit mack);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      rd_bit(b);
      v[i] = b;
    end
    wr_bit(!mack);
  endtask

  task automatic do_reset(input logic strap);
    rst_ni = 1'b0; strap_i = strap; m_scl = 1'b1; m_sda = 1'b1;
    repeat (5) @(negedge clk);
    rst_ni = 1'b1;
    repeat (5) @(negedge clk);
    chk(sda_oe_o == 1'b0, "R12", "reset sda_oe_o", sda_oe_o, 0);
    chk(reg_we_o == 1'b0, "R12", "reset reg_we_o", reg_we_o, 0);
    chk(reg_addr_o == 8'h00, "R12", "reset reg_addr_o", reg_addr_o, 0);
  endtask

  task automatic write_txn(input logic [7:0] ab, input logic [7:0] idx,
                           input logic [7:0] dat, input string req);
    bit a;
    i2c_start();
    send_byte(ab, a);  chk(a, req, "address ack", a, 1);
    send_byte(idx, a); chk(a, "R6", "index ack", a, 1);
    exp_idx_q.push_back(idx); exp_dat_q.push_back(dat);
    send_byte(dat, a); chk(a, "R4", "data ack", a, 1);
    exp_mem[idx] = dat;
    i2c_stop();
    chk(exp_idx_q.size() == 0, "R9", "pending strobes", exp_idx_q.size(), 0);
  endtask

  task automatic read_one(input logic [7:0] ab, input logic [7:0] expv,
                          input string req);
    bit a;
    logic [7:0] v;
    i2c_start();
    send_byte(ab, a); chk(a, req, "read address ack", a, 1);
    recv_byte(v, 1'b0);
    chk(v == expv, req, "read data", v, expv);
    i2c_stop();
  endtask

  initial begin
    bit a;
    logic [7:0] v;
    for (int i = 0; i < 256; i++) begin
      rf[i] = 8'(i) ^ 8'h5A;
      exp_mem[i] = 8'(i) ^ 8'h5A;
    end

    do_reset(1'b0);

    // R1 R4 R6: full write at strap-low address
    write_txn(8'h9C, 8'h12, 8'hA5, "R1");

    // R7 R8: read, master ACK repeats, NACK releases
    i2c_start();
    send_byte(8'h9D, a); chk(a, "R7", "read address ack", a, 1);
    recv_byte(v, 1'b1);  chk(v == exp_mem[8'h12], "R7", "first read byte", v, exp_mem[8'h12]);
    recv_byte(v, 1'b0);  chk(v == exp_mem[8'h12], "R8", "repeat after ACK", v, exp_mem[8'h12]);
    recv_byte(v, 1'b0);  chk(v == 8'hFF, "R8", "released after NACK", v, 8'hFF);
    i2c_stop();

    // R5: index-only write
    i2c_start();
    send_byte(8'h9C, a); chk(a, "R5", "address ack", a, 1);
    send_byte(8'h30, a); chk(a, "R5", "index ack", a, 1);
    i2c_stop();
    read_one(8'h9D, exp_mem[8'h30], "R5");

    // R3: foreign address ignored, pointer untouched
    i2c_start();
    send_byte(8'h6E, a); chk(!a, "R3", "foreign address nack", a, 0);
    send_byte(8'h40, a); chk(!a, "R3", "index after mismatch", a, 0);
    send_byte(8'h77, a); chk(!a, "R3", "data after mismatch", a, 0);
    i2c_stop();
    read_one(8'h9D, exp_mem[8'h30], "R3");

    // R11: extra byte after data
    i2c_start();
    send_byte(8'h9C, a); chk(a, "R11", "address ack", a, 1);
    send_byte(8'h50, a); chk(a, "R11", "index ack", a, 1);
    exp_idx_q.push_back(8'h50); exp_dat_q.push_back(8'h11);
    send_byte(8'h11, a); chk(a, "R11", "data ack", a, 1);
    exp_mem[8'h50] = 8'h11;
    send_byte(8'h22, a); chk(!a, "R11", "extra byte nack", a, 0);
    i2c_stop();
    read_one(8'h9D, 8'h11, "R11");

    // R10: repeated START after full index byte
    i2c_start();
    send_byte(8'h9C, a); chk(a, "R10", "address ack", a, 1);
    send_byte(8'h60, a); chk(a, "R10", "index ack", a, 1);
    i2c_rstart();
    send_byte(8'h9D, a); chk(a, "R10", "read address after rstart", a, 1);
    recv_byte(v, 1'b0);  chk(v == exp_mem[8'h60], "R10", "read after rstart", v, exp_mem[8'h60]);
    i2c_stop();

    // R10: repeated START in the middle of a byte
    i2c_start();
    send_byte(8'h9C, a); chk(a, "R10", "address ack", a, 1);
    wr_bit(1'b1); wr_bit(1'b0); wr_bit(1'b1);
    i2c_rstart();
    send_byte(8'h9C, a); chk(a, "R10", "address after mid-byte rstart", a, 1);
    send_byte(8'h22, a); chk(a, "R10", "index after mid-byte rstart", a, 1);
    i2c_stop();
    read_one(8'h9D, exp_mem[8'h22], "R10");

    // R2: strap change without reset has no effect
    strap_i = 1'b1;
    i2c_start();
    send_byte(8'h6E, a); chk(!a, "R2", "new strap ignored", a, 0);
    i2c_stop();
    read_one(8'h9D, exp_mem[8'h22], "R2");

    // R2: reset with strap high
    do_reset(1'b1);
    i2c_start();
    send_byte(8'h9C, a); chk(!a, "R2", "low address after high strap", a, 0);
    i2c_stop();
    write_txn(8'h6E, 8'h33, 8'hC3, "R2");
    read_one(8'h6F, 8'hC3, "R2");

    repeat (20) @(negedge clk);
    chk(exp_idx_q.size() == 0, "R9", "strobes outstanding at end", exp_idx_q.size(), 0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog R1..R12 actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule